// File: doc/BRIEF.md
# Rotate Unit with Carry and Zero Flags

This block is the rotating part of a processor ALU. Each accepted request carries a 32-bit operand, a rotate amount, a direction select and two separate flag write-enables. The operand is rotated by a logarithmic barrel network, so every amount from 0 to 31 has the same latency. The rotated word and the computed carry and zero values go into one output register stage.

Requests enter through a valid/ready handshake and results leave through one. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle (`!out_valid || out_ready`). A result stays in the output register, unchanged, until `out_ready` takes it. The carry and zero flags are plain state outputs. They change only on an accepted request whose matching write-enable is set.

Top module: `rot_unit`

## Requirements
- R1: A left rotate (`in_dir`=0) returns bits [63:32] of the doubled operand {D,D} shifted left by the amount. A right rotate (`in_dir`=1) returns bits [31:0] of {D,D} shifted right by the amount.
- R2: Only `in_amt[4:0]` sets the rotation. Setting higher amount bits has no effect on the result or on the carry.
- R3: For a nonzero amount, the carry value is the last bit rotated out. For a left rotate this is the bit that wraps into result bit 0. For a right rotate it is the bit that wraps into result bit 31.
- R4: For an amount of zero, the data passes through unchanged. The carry value is operand bit 31 for a left rotate and operand bit 0 for a right rotate.
- R5: The zero value is 1 exactly when the 32-bit rotated result is zero.
- R6: `flag_c` is written on acceptance only when `in_wc`=1, and `flag_z` only when `in_wz`=1. Otherwise each keeps its previous value.
- R7: The result appears on `out_data` with `out_valid`=1 one clock edge after acceptance, for every amount.
- R8: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0, and `out_data` and both flags hold.
- R9: A synchronous active-high reset clears `flag_c`, `flag_z` and `out_valid` to 0.
- R10: Reference points: rotating 0xAAAAAAAA left by 1 gives 0x55555555. Rotating 0xDEADBEEF left by 1 gives 0xBD5B7DDF with carry 1. Rotating 0xDEADBEEF right by 4 gives 0xFDEADBEE with carry 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_data | input | 32 | Operand to rotate |
| in_amt | input | 8 | Rotate amount; only bits [4:0] count |
| in_dir | input | 1 | 0 = rotate left, 1 = rotate right |
| in_wc | input | 1 | Write enable for the carry flag |
| in_wz | input | 1 | Write enable for the zero flag |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Rotated result |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |

## Verification
The hardest case to reach from the ports is a stalled output with a new request waiting. Here the flags and data must hold even though a request with different flag outcomes is already presented. The bench holds `out_ready` low after one accepted request and presents a second request with both write-enables set and a different expected carry. It checks that nothing moves until the stall is released. The zero-amount carry fallback is also hard to observe, because the fallback bit differs from the result's own end bit. It is reached with operands whose bit 31 and bit 0 differ.

// File: rtl/rot_pkg.sv
package rot_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LOG_W  = $clog2(DATA_W);

  typedef enum logic {
    ROT_LEFT  = 1'b0,
    ROT_RIGHT = 1'b1
  } rot_dir_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              carry;
    logic              zero;
  } rot_res_t;
endpackage

// File: rtl/rot_stage.sv
// One fixed-distance level of the barrel: rotates by SH when enabled.
module rot_stage #(
  parameter int unsigned W  = 32,
  parameter int unsigned SH = 1
) (
  input  logic [W-1:0] d,
  input  logic         en,
  input  logic         dir,
  output logic [W-1:0] q
);
  logic [W-1:0] left_v;
  logic [W-1:0] right_v;

  assign left_v  = {d[W-SH-1:0], d[W-1:W-SH]};
  assign right_v = {d[SH-1:0], d[W-1:SH]};

  always_comb begin
    if (!en)      q = d;
    else if (dir) q = right_v;
    else          q = left_v;
  end
endmodule

// File: rtl/rot_barrel.sv
// Logarithmic rotator: LOG levels of power-of-two rotations.
module rot_barrel #(
  parameter int unsigned W   = 32,
  parameter int unsigned LOG = $clog2(W)
) (
  input  logic [W-1:0]   d,
  input  logic [LOG-1:0] amt,
  input  logic           dir,
  output logic [W-1:0]   q
);
  logic [W-1:0] lvl [0:LOG];

  assign lvl[0] = d;

  for (genvar k = 0; k < LOG; k++) begin : g_lvl
    rot_stage #(.W(W), .SH(1 << k)) u_stage (
      .d   (lvl[k]),
      .en  (amt[k]),
      .dir (dir),
      .q   (lvl[k+1])
    );
  end

  assign q = lvl[LOG];
endmodule

// File: rtl/rot_flags.sv
// Carry and zero values for one rotate.
module rot_flags #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] src,
  input  logic [W-1:0] rot,
  input  logic         amt_zero,
  input  logic         dir,
  output logic         carry,
  output logic         zero
);
  logic wrapped;
  logic fallback;

  // The last bit out of a rotate is the one that wrapped to the far end.
  assign wrapped  = dir ? rot[W-1] : rot[0];
  assign fallback = dir ? src[0]   : src[W-1];
  assign carry    = amt_zero ? fallback : wrapped;
  assign zero     = (rot == '0);
endmodule

// File: rtl/rot_unit.sv
module rot_unit
  import rot_pkg::*;
#(
  parameter int unsigned AMT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [AMT_W-1:0]  in_amt,
  input  logic              in_dir,
  input  logic              in_wc,
  input  logic              in_wz,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              flag_c,
  output logic              flag_z
);
  localparam int unsigned USE_W = LOG_W;

  logic [USE_W-1:0] amt_lo;
  logic             accept;
  rot_res_t         comb_res;

  assign amt_lo   = in_amt[USE_W-1:0];
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  rot_barrel #(.W(DATA_W), .LOG(USE_W)) u_barrel (
    .d   (in_data),
    .amt (amt_lo),
    .dir (in_dir),
    .q   (comb_res.data)
  );

  rot_flags #(.W(DATA_W)) u_flags (
    .src      (in_data),
    .rot      (comb_res.data),
    .amt_zero (amt_lo == '0),
    .dir      (in_dir),
    .carry    (comb_res.carry),
    .zero     (comb_res.zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      flag_c    <= 1'b0;
      flag_z    <= 1'b0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_data  <= comb_res.data;
        if (in_wc) flag_c <= comb_res.carry;
        if (in_wz) flag_z <= comb_res.zero;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_ROTL_ONE: assert property (@(posedge clk) disable iff (rst)
    accept && !in_dir && amt_lo == 1 |=> out_data == {$past(in_data[DATA_W-2:0]), $past(in_data[DATA_W-1])}); // R1
  AST_HIGH_AMT_IGNORED: assert property (@(posedge clk) disable iff (rst)
    accept && in_dir && in_amt == {{(AMT_W-USE_W){1'b1}}, {USE_W{1'b0}}} |=> out_data == $past(in_data)); // R2
  AST_CARRY_ZERO_LEFT: assert property (@(posedge clk) disable iff (rst)
    accept && in_wc && !in_dir && amt_lo == 0 |=> flag_c == $past(in_data[DATA_W-1])); // R4
  AST_CARRY_ZERO_RIGHT: assert property (@(posedge clk) disable iff (rst)
    accept && in_wc && in_dir && amt_lo == 0 |=> flag_c == $past(in_data[0])); // R4
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    accept && in_wz |=> flag_z == (out_data == '0)); // R5
  AST_C_KEPT: assert property (@(posedge clk) disable iff (rst)
    !(accept && in_wc) |=> $stable(flag_c)); // R6
  AST_Z_KEPT: assert property (@(posedge clk) disable iff (rst)
    !(accept && in_wz) |=> $stable(flag_z)); // R6
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> !out_valid && !flag_c && !flag_z); // R9
endmodule

// File: tb/tb_rot_unit.sv
`timescale 1ns/1ps
module tb_rot_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready;
  logic [31:0] in_data;
  logic [7:0]  in_amt;
  logic        in_dir, in_wc, in_wz;
  logic        out_valid, out_ready;
  logic [31:0] out_data;
  logic        flag_c, flag_z;

  int checks = 0;
  int errors = 0;
  logic exp_c = 1'b0;
  logic exp_z = 1'b0;

  always #4 clk = ~clk;

  rot_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_amt(in_amt), .in_dir(in_dir), .in_wc(in_wc),
    .in_wz(in_wz), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .flag_c(flag_c), .flag_z(flag_z)
  );

  function automatic logic [31:0] model_rot(input logic [31:0] d, input int n, input logic dir);
    logic [63:0] dbl;
    dbl = {d, d};
    if (!dir) begin dbl = dbl << n; return dbl[63:32]; end
    else      begin dbl = dbl >> n; return dbl[31:0]; end
  endfunction

  function automatic logic model_carry(input logic [31:0] d, input int n, input logic dir);
    if (n == 0) return dir ? d[0] : d[31];
    // last bit rotated out: left -> source bit 32-n, right -> source bit n-1
    return dir ? d[n-1] : d[32-n];
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One request with out_ready high; results checked at the next falling edge.
  task automatic send_check(input string req, input logic [31:0] d, input logic [7:0] a,
                            input logic dir, input logic wc, input logic wz,
                            input logic [31:0] exp_d, input logic exp_carry);
    logic [31:0] r;
    @(negedge clk);
    in_valid = 1; in_data = d; in_amt = a; in_dir = dir; in_wc = wc; in_wz = wz;
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    r = exp_d;
    if (wc) exp_c = exp_carry;
    if (wz) exp_z = (r == 0);
    check(req, "out_valid", {31'd0, out_valid}, 32'd1);
    check(req, "data", out_data, exp_d);
    check(req, "flag_c", {31'd0, flag_c}, {31'd0, exp_c});
    check(req, "flag_z", {31'd0, flag_z}, {31'd0, exp_z});
  endtask

  task automatic t_reset;
    rst = 1; in_valid = 0; out_ready = 1; in_data = '0; in_amt = '0;
    in_dir = 0; in_wc = 0; in_wz = 0;
    repeat (3) @(negedge clk);
    check("R9", "flag_c", {31'd0, flag_c}, 32'd0);
    check("R9", "flag_z", {31'd0, flag_z}, 32'd0);
    check("R9", "out_valid", {31'd0, out_valid}, 32'd0);
    rst = 0;
  endtask

  task automatic t_known;
    send_check("R10", 32'hAAAAAAAA, 8'd1, 0, 1, 1, 32'h55555555, 1'b1);
    send_check("R10", 32'hDEADBEEF, 8'd1, 0, 1, 1, 32'hBD5B7DDF, 1'b1);
    send_check("R10", 32'hDEADBEEF, 8'd4, 1, 1, 1, 32'hFDEADBEE, 1'b1);
  endtask

  task automatic t_zero_amt;
    // bit31 and bit0 differ so the fallback is visible (R4)
    send_check("R4", 32'h80000000, 8'd0, 0, 1, 1, 32'h80000000, 1'b1);
    send_check("R4", 32'h80000000, 8'd0, 1, 1, 1, 32'h80000000, 1'b0);
    send_check("R4", 32'h00000001, 8'd0, 0, 1, 1, 32'h00000001, 1'b0);
    send_check("R4", 32'h00000001, 8'd0, 1, 1, 1, 32'h00000001, 1'b1);
  endtask

  task automatic t_high_bits;
    send_check("R2", 32'h12345678, 8'hE1, 0, 1, 1, model_rot(32'h12345678, 1, 0), model_carry(32'h12345678, 1, 0));
    send_check("R2", 32'h80000001, 8'h20, 1, 1, 1, 32'h80000001, 1'b1);
  endtask

  task automatic t_zero_flag;
    send_check("R5", 32'h0, 8'd7, 0, 1, 1, 32'h0, 1'b0);
    send_check("R5", 32'h00010000, 8'd16, 1, 0, 1, 32'h00000001, 1'b0);
  endtask

  task automatic t_enables;
    // set both flags, then rotate with enables off: both keep (R6)
    send_check("R6", 32'h80000000, 8'd1, 0, 1, 0, 32'h00000001, 1'b1);
    send_check("R6", 32'h0, 8'd3, 0, 0, 1, 32'h0, 1'b0);
    send_check("R6", 32'h00000002, 8'd1, 1, 0, 0, 32'h00000001, 1'b0);
    send_check("R6", 32'h00000002, 8'd1, 1, 1, 0, 32'h00000001, 1'b0);
  endtask

  task automatic t_sweep;
    logic [31:0] d;
    d = 32'hC3A50F96;
    for (int dir = 0; dir < 2; dir++) begin
      for (int n = 0; n < 32; n++) begin
        send_check(dir ? "R1 R3 R7 right" : "R1 R3 R7 left", d, n[7:0], dir[0], 1, 1,
                   model_rot(d, n, dir[0]), model_carry(d, n, dir[0]));
      end
    end
  endtask

  task automatic t_stall;
    logic [31:0] a_exp;
    // first request: 0x1 left by 0 -> carry 0
    @(negedge clk);
    out_ready = 0;
    in_valid = 1; in_data = 32'h00000001; in_amt = 8'd0; in_dir = 0; in_wc = 1; in_wz = 1;
    a_exp = 32'h00000001; exp_c = 1'b0; exp_z = 1'b0;
    @(negedge clk);
    // second request waits: would give carry 1 and zero 0
    in_data = 32'h80000000; in_amt = 8'd1; in_dir = 0;
    check("R8", "in_ready low", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    check("R8", "data held", out_data, a_exp);
    check("R8", "flag_c held", {31'd0, flag_c}, {31'd0, exp_c});
    check("R8", "out_valid held", {31'd0, out_valid}, 32'd1);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    exp_c = 1'b1;
    check("R8", "after release data", out_data, 32'h00000001);
    check("R8", "after release flag_c", {31'd0, flag_c}, {31'd0, exp_c});
    @(negedge clk);
    check("R7", "drained", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_known();
    t_zero_amt();
    t_high_bits();
    t_zero_flag();
    t_enables();
    t_sweep();
    t_stall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule